// File: doc/BRIEF.md
# Page Program Buffer with In-Page Wrap

This block takes a serial page-program transaction and turns it into a masked write to a byte-addressed storage array. The serial stream arrives as single bits, each marked by a one-cycle strobe in the system clock domain while an active-low select is held low. The first byte is an opcode. The next three bytes form a 24-bit target address. Every byte after that is payload. Payload bytes go into a 256-entry staging page. The first one lands at the offset given by the low address byte, and the offset then advances and folds back to zero at the end of the page. A per-offset flag records which entries were filled. These flags are cleared whenever a new select window opens.

When the select line returns high, the block decides whether to commit. It commits only if the stream stopped on a whole-byte boundary with at least one payload byte, the external status unit reports writes enabled and not busy, and the target page is outside the locked region. A commit walks the staging page one offset per clock. For every flagged offset it stores the old array byte ANDed with the staged byte, so a commit can clear bits but never set them. When the walk is done, the block sends a one-cycle pulse to the status unit so that it can start its timed busy period. A read port lets the rest of the system inspect the array.

Top module: `page_program_buffer`

## Requirements
- R1: After reset every array byte reads FFh and `cycle_start_o` is low.
- R2: Bits are taken MSB first, one per clock in which `bit_stb` is high and `cs_n` is low. Only opcode 02h starts a program. Any other opcode makes the whole select window have no effect on the array and produce no pulse.
- R3: Payload byte k goes to page offset (A[7:0] + k) mod 256, so bytes that run past offset FFh continue at offset 00h of the same page.
- R4: When more than 256 payload bytes are sent, each offset holds the latest byte written to it, so only the final 256 bytes are committed.
- R5: Offsets that received no payload byte keep their previous array contents, and so do all other pages.
- R6: A committed byte equals the previous array byte ANDed with the staged byte.
- R7: No commit happens unless the number of bits since the last complete byte is zero when `cs_n` rises and at least one payload byte was received.
- R8: A commit needs `wel_i` = 1 and `busy_i` = 0 in the clock where `cs_n` is first seen high.
- R9: With lock code `bp_i` = b (b > 0), and P pages of which the addressed page is page p, the locked pages are those with p >= P - (P >> (7 - b)). A write to a locked page does not commit. `bp_i` = 0 locks nothing, and `bp_i` = 7 locks all pages.
- R10: A commit takes 256 clocks and ends with `cycle_start_o` high for exactly one clock. A select window that opens while a commit is in progress has no effect.
- R11: The target page is address bits [MEM_AW-1:8]. Higher address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low transaction select |
| bit_stb | input | 1 | One-cycle strobe marking a valid serial bit |
| bit_in | input | 1 | Serial data bit |
| wel_i | input | 1 | Write-enable latch state from the status unit |
| busy_i | input | 1 | Write-in-progress state from the status unit |
| bp_i | input | 3 | Lock code selecting the protected upper pages |
| cycle_start_o | output | 1 | One-cycle pulse after a completed commit |
| rd_addr_i | input | MEM_AW | Array read address |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` |

## Verification
The assertions assume that `bit_stb` is high only while `cs_n` is low, and that `cs_n` never changes in the same clock as a strobe. They also assume that `wel_i`, `busy_i` and `bp_i` are steady in the clock where the select rises. The stimulus meets these assumptions by leaving a low strobe clock after every bit and two idle clocks on each side of every select edge. It holds the status inputs constant for the whole select window. Expected array contents come from a byte-level model that applies the wrap, the last-write rule and the AND merge.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
    localparam int unsigned PAGE_AW  = 8;
    localparam int unsigned BYTE_W   = 8;
    localparam logic [7:0]  OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_COMMIT,
        ST_SKIP
    } ppb_state_e;
endpackage

// File: rtl/ppb_shift.sv
module ppb_shift #(
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          bit_stb,
    input  logic          bit_in,
    output logic          byte_vld,
    output logic [BW-1:0] byte_data,
    output logic          on_bnd
);
    localparam int unsigned CW = $clog2(BW);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [BW-2:0] sh;
        logic          vld;
        logic [BW-1:0] data;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (cs_n) begin
            s_d.cnt = '0;
        end else if (bit_stb) begin
            s_d.sh  = {s_q.sh[BW-3:0], bit_in};
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CW'(BW - 1)) begin
                s_d.vld  = 1'b1;
                s_d.data = {s_q.sh, bit_in};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_vld  = s_q.vld;
    assign byte_data = s_q.data;
    assign on_bnd    = (s_q.cnt == '0);

    // R2: a completed byte is only ever produced by a strobe inside the window
    p_byte_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> ($past(bit_stb) && !$past(cs_n)));
endmodule

// File: rtl/ppb_pagebuf.sv
module ppb_pagebuf
    import ppb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               wr_i,
    input  logic [PAGE_AW-1:0] wr_idx_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    input  logic [PAGE_AW-1:0] rd_idx_i,
    output logic [BYTE_W-1:0]  rd_data_o,
    output logic               rd_vld_o
);
    localparam int unsigned NB = 1 << PAGE_AW;

    typedef struct packed {
        logic [NB-1:0][BYTE_W-1:0] data;
        logic [NB-1:0]             mask;
    } pbuf_t;

    pbuf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr_i) begin
            b_d.mask = '0;
        end else if (wr_i) begin
            b_d.data[wr_idx_i] = wr_data_i;
            b_d.mask[wr_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign rd_data_o = b_q.data[rd_idx_i];
    assign rd_vld_o  = b_q.mask[rd_idx_i];

    // R5: the set of filled offsets only grows inside one window
    p_mask_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ($countones(b_q.mask) >= $countones($past(b_q.mask))));

    // R4: a write always leaves its offset flagged with the new byte
    p_last_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> (b_q.mask[$past(wr_idx_i)]
                              && b_q.data[$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/ppb_mem.sv
module ppb_mem
    import ppb_pkg::*;
#(
    parameter int unsigned MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [MEM_AW-1:0] waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] old_o,
    input  logic [MEM_AW-1:0] raddr_i,
    output logic [BYTE_W-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << MEM_AW;

    logic [DEPTH-1:0][BYTE_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

    assign old_o   = mem_q[waddr_i];
    assign rdata_o = mem_q[raddr_i];

    // R6: a write may only clear bits of the stored byte
    p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> ((wdata_i & ~mem_q[waddr_i]) == '0));

    // R6: the written value is what the array holds afterwards
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/ppb_prot.sv
module ppb_prot #(
    parameter int unsigned PG_W = 2
) (
    input  logic [2:0]      bp_i,
    input  logic [PG_W-1:0] page_i,
    output logic            locked_o
);
    localparam logic [PG_W:0] NPAGES = (PG_W + 1)'(1) << PG_W;

    logic [PG_W:0] span;
    logic [PG_W:0] floor_pg;

    always_comb begin
        span     = NPAGES >> (3'd7 - bp_i);
        floor_pg = NPAGES - span;
        locked_o = (bp_i != 3'd0) && ({1'b0, page_i} >= floor_pg);
    end
endmodule

// File: rtl/page_program_buffer.sv
module page_program_buffer
    import ppb_pkg::*;
#(
    parameter int unsigned MEM_AW     = 10,
    parameter int unsigned ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              wel_i,
    input  logic              busy_i,
    input  logic [2:0]        bp_i,
    output logic              cycle_start_o,
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    localparam int unsigned PG_W = MEM_AW - PAGE_AW;
    localparam int unsigned AC_W = $clog2(ADDR_BYTES);
    localparam logic [PAGE_AW-1:0] LAST_OFF = '1;

    typedef struct packed {
        ppb_state_e         state;
        logic [MEM_AW-1:0]  addr;
        logic [AC_W-1:0]    acnt;
        logic [PAGE_AW-1:0] idx;
        logic               got;
        logic [PAGE_AW-1:0] ptr;
        logic               start;
    } top_t;

    top_t t_d, t_q;

    logic              byte_vld, on_bnd, locked;
    logic [BYTE_W-1:0] byte_data;
    logic              pb_clr, pb_wr, pb_vld;
    logic [BYTE_W-1:0] pb_data, mem_old;
    logic              mem_we;
    logic [PG_W-1:0]   page;

    assign page = t_q.addr[MEM_AW-1:PAGE_AW];

    ppb_shift #(.BW(BYTE_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .bit_stb   (bit_stb),
        .bit_in    (bit_in),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .on_bnd    (on_bnd)
    );

    ppb_pagebuf i_pagebuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (pb_clr),
        .wr_i      (pb_wr),
        .wr_idx_i  (t_q.addr[PAGE_AW-1:0] + t_q.idx),
        .wr_data_i (byte_data),
        .rd_idx_i  (t_q.ptr),
        .rd_data_o (pb_data),
        .rd_vld_o  (pb_vld)
    );

    ppb_mem #(.MEM_AW(MEM_AW)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i ({page, t_q.ptr}),
        .wdata_i (mem_old & pb_data),
        .old_o   (mem_old),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    ppb_prot #(.PG_W(PG_W)) i_prot (
        .bp_i     (bp_i),
        .page_i   (page),
        .locked_o (locked)
    );

    always_comb begin
        t_d       = t_q;
        t_d.start = 1'b0;
        pb_clr    = 1'b0;
        pb_wr     = 1'b0;
        mem_we    = 1'b0;
        unique case (t_q.state)
            ST_IDLE: begin
                if (!cs_n) begin
                    t_d.state = ST_CMD;
                    pb_clr    = 1'b1;
                end
            end
            ST_CMD: begin
                if (cs_n) begin
                    t_d.state = ST_IDLE;
                end else if (byte_vld) begin
                    t_d.state = (byte_data == OP_WRITE) ? ST_ADDR : ST_SKIP;
                    t_d.acnt  = '0;
                end
            end
            ST_ADDR: begin
                if (byte_vld) begin
                    t_d.addr = {t_q.addr[MEM_AW-BYTE_W-1:0], byte_data};
                    t_d.acnt = t_q.acnt + 1'b1;
                    if (t_q.acnt == AC_W'(ADDR_BYTES - 1)) begin
                        t_d.state = ST_DATA;
                        t_d.idx   = '0;
                        t_d.got   = 1'b0;
                    end
                end
                if (cs_n) t_d.state = ST_IDLE;
            end
            ST_DATA: begin
                if (byte_vld) begin
                    pb_wr   = 1'b1;
                    t_d.idx = t_q.idx + 1'b1;
                    t_d.got = 1'b1;
                end
                if (cs_n) begin
                    if ((t_q.got || byte_vld) && on_bnd && wel_i && !busy_i && !locked) begin
                        t_d.state = ST_COMMIT;
                        t_d.ptr   = '0;
                    end else begin
                        t_d.state = ST_IDLE;
                    end
                end
            end
            ST_COMMIT: begin
                mem_we  = pb_vld;
                t_d.ptr = t_q.ptr + 1'b1;
                if (t_q.ptr == LAST_OFF) begin
                    t_d.start = 1'b1;
                    t_d.state = cs_n ? ST_IDLE : ST_SKIP;
                end
            end
            ST_SKIP: begin
                if (cs_n) t_d.state = ST_IDLE;
            end
            default: t_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q       <= '0;
            t_q.state <= ST_IDLE;
        end else begin
            t_q <= t_d;
        end
    end

    assign cycle_start_o = t_q.start;

    // R8: commit entry only with writes enabled and the status unit idle
    p_commit_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.state == ST_COMMIT && $past(t_q.state) != ST_COMMIT)
            |-> ($past(wel_i) && !$past(busy_i)));

    // R7: commit entry only when the window closed on a byte boundary
    p_commit_bnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.state == ST_COMMIT && $past(t_q.state) != ST_COMMIT)
            |-> ($past(on_bnd) && $past(cs_n)));

    // R9: a locked page never reaches the commit walk
    p_commit_prot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.state == ST_COMMIT && $past(t_q.state) != ST_COMMIT) |-> !$past(locked));

    // R10: the completion pulse lasts one clock
    p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |=> !cycle_start_o);

    // R10: the walk is not interrupted by select activity
    p_walk_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.state == ST_COMMIT && t_q.ptr != LAST_OFF) |=> (t_q.state == ST_COMMIT));
endmodule

// File: tb/test_page_program_buffer.sv
module test_page_program_buffer;
    localparam int MEM_AW = 10;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int NVEC   = 12;

    // {addr[23:0], nbytes[9:0], seed[7:0], extra_bits[2:0], wel, busy, bp[2:0], expect_commit}
    localparam logic [50:0] VECS [NVEC] = '{
        {24'h000010, 10'd4,   8'hA5, 3'd0, 1'b1, 1'b0, 3'd0, 1'b1},
        {24'h0001FE, 10'd5,   8'h5A, 3'd0, 1'b1, 1'b0, 3'd0, 1'b1},
        {24'h000210, 10'd300, 8'h13, 3'd0, 1'b1, 1'b0, 3'd0, 1'b1},
        {24'h000010, 10'd4,   8'h3C, 3'd0, 1'b1, 1'b0, 3'd0, 1'b1},
        {24'h000300, 10'd3,   8'h00, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0},
        {24'h000300, 10'd3,   8'h00, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0},
        {24'h000300, 10'd3,   8'h00, 3'd0, 1'b1, 1'b0, 3'd5, 1'b0},
        {24'h000080, 10'd2,   8'h0F, 3'd0, 1'b1, 1'b0, 3'd5, 1'b1},
        {24'h000200, 10'd2,   8'h00, 3'd0, 1'b1, 1'b0, 3'd6, 1'b0},
        {24'h000340, 10'd2,   8'h00, 3'd3, 1'b1, 1'b0, 3'd0, 1'b0},
        {24'h000C40, 10'd2,   8'h81, 3'd0, 1'b1, 1'b0, 3'd0, 1'b1},
        {24'h000350, 10'd0,   8'h00, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n, cs_n, bit_stb, bit_in, wel_i, busy_i;
    logic [2:0] bp_i;
    logic cycle_start_o;
    logic [MEM_AW-1:0] rd_addr_i;
    logic [7:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    page_program_buffer #(.MEM_AW(MEM_AW)) i_page_program_buffer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .bit_in(bit_in),
        .wel_i(wel_i), .busy_i(busy_i), .bp_i(bp_i), .cycle_start_o(cycle_start_o),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    always @(posedge clk) if (rst_n && cycle_start_o) pulses++;

    function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
        return seed + 8'(i) * 8'd29 + 8'(i >> 8) * 8'd101;
    endfunction

    function automatic string vtag(input int k);
        case (k)
            0: return "R3";  1: return "R3";  2: return "R4";  3: return "R6";
            4: return "R8";  5: return "R8";  6: return "R9";  7: return "R9";
            8: return "R9";  9: return "R7";  10: return "R11"; default: return "R7";
        endcase
    endfunction

    task automatic send_byte(input logic [7:0] b);
        for (int j = 7; j >= 0; j--) begin
            @(negedge clk); bit_in = b[j]; bit_stb = 1'b1;
            @(negedge clk); bit_stb = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] op, input logic [23:0] a, input int n,
                         input logic [7:0] seed, input int extra);
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        send_byte(op);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
        for (int i = 0; i < n; i++) send_byte(dbyte(seed, i));
        for (int e = 0; e < extra; e++) begin
            @(negedge clk); bit_in = 1'b0; bit_stb = 1'b1;
            @(negedge clk); bit_stb = 1'b0;
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic model_apply(input logic [23:0] a, input int n, input logic [7:0] seed);
        logic [7:0] stage [256];
        logic       flag  [256];
        for (int o = 0; o < 256; o++) flag[o] = 1'b0;
        for (int i = 0; i < n; i++) begin
            stage[(a[7:0] + i) % 256] = dbyte(seed, i);
            flag[(a[7:0] + i) % 256]  = 1'b1;
        end
        for (int o = 0; o < 256; o++)
            if (flag[o]) model[{a[9:8], 8'(o)}] &= stage[o];
    endtask

    task automatic check_mem(input string tag);
        int bad = 0;
        logic [MEM_AW-1:0] first_a = '0;
        logic [7:0] got_v = '0, exp_v = '0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr_i = MEM_AW'(a);
            #1;
            if (rd_data_o !== model[a]) begin
                if (bad == 0) begin first_a = MEM_AW'(a); got_v = rd_data_o; exp_v = model[a]; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s array mismatch at %0h: actual=%02h expected=%02h (%0d bytes differ)",
                     tag, first_a, got_v, exp_v, bad);
        end
    endtask

    task automatic check_pulses(input string tag, input int base, input int want);
        checks++;
        if (pulses - base != want) begin
            errors++;
            $display("FAIL %s completion pulses: actual=%0d expected=%0d", tag, pulses - base, want);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        logic [50:0] v;
        rst_n = 1'b0; cs_n = 1'b1; bit_stb = 1'b0; bit_in = 1'b0;
        wel_i = 1'b0; busy_i = 1'b0; bp_i = 3'd0; rd_addr_i = '0;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        repeat (5) @(negedge clk);

        // R1: reset state
        checks++;
        if (cycle_start_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 pulse in reset: actual=%b expected=0", cycle_start_o);
        end
        check_mem("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            v = VECS[k];
            wel_i = v[5]; busy_i = v[4]; bp_i = v[3:1];
            base = pulses;
            frame(8'h02, v[50:27], int'(v[26:17]), v[16:9], int'(v[8:6]));
            repeat (300) @(negedge clk);
            if (v[0]) model_apply(v[50:27], int'(v[26:17]), v[16:9]);
            check_pulses(vtag(k), base, v[0] ? 1 : 0);
            check_mem(vtag(k));
        end

        // R2: foreign opcode has no effect
        wel_i = 1'b1; busy_i = 1'b0; bp_i = 3'd0;
        base = pulses;
        frame(8'h03, 24'h000120, 2, 8'h00, 0);
        repeat (300) @(negedge clk);
        check_pulses("R2", base, 0);
        check_mem("R2");

        // R10: a window opened during the commit walk is ignored
        base = pulses;
        frame(8'h02, 24'h000140, 1, 8'h77, 0);
        frame(8'h02, 24'h000150, 1, 8'h00, 0);
        repeat (400) @(negedge clk);
        model_apply(24'h000140, 1, 8'h77);
        check_pulses("R10", base, 1);
        check_mem("R10");

        // R5: short write leaves the rest of page 1 untouched
        base = pulses;
        frame(8'h02, 24'h000160, 1, 8'hF0, 0);
        repeat (300) @(negedge clk);
        model_apply(24'h000160, 1, 8'hF0);
        check_pulses("R5", base, 1);
        check_mem("R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule